// File: doc/BRIEF.md
# Bit-Serial Triple-Plus-One Unit

This block takes an unsigned number one bit per clock on a single input line, least significant bit first. In the same cycle it returns, on a single output line, the matching bit of three times that number plus one, also least significant bit first. No multiplier or parallel register is involved. The block adds the number to a copy of itself shifted left by one place, with an initial carry of one, so each step is a single three-input addition.

A word starts when the caller raises the synchronous start line for at least one clock, then feeds the bits of X. The result can be up to two bits wider than the operand, so the caller appends two zero bits after the most significant bit of X to collect the full result. The output is a Mealy output: it depends on the current input bit and the stored state, and it is valid in the same cycle as that input bit. The stored state is the previous input bit and one carry bit. Because the largest sum is three, one carry bit is always enough.

Top module: `triple_plus_one`

## Requirements
- R1: After any clock edge at which `rst` is high, the stored previous bit is 0 and the stored carry is 1, so the first output bit of a word is the inverse of the first input bit.
- R2: At every edge where `rst` is low, the stored previous bit takes the value `x_bit` had in that cycle.
- R3: At every edge where `rst` is low, the stored carry becomes the majority of the current `x_bit`, the stored previous bit and the stored carry.
- R4: `y_bit` in each cycle equals the exclusive-or of that cycle's `x_bit`, the stored previous bit and the stored carry. It changes in the same cycle as `x_bit`, with no register in the path.
- R5: If an N-bit value X is fed LSB first and followed by two zero bits, the N+2 output bits, read LSB first, form exactly 3·X+1.
- R6: A word of all zeros gives a first output bit of 1 and zeros after it.
- R7: An N-bit word of all ones gives 3·2^N−2 in N+2 output bits, so no carry is lost at the top.
- R8: Raising `rst` in the middle of a word discards the partial state, and the next word is computed correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous, active-high start; loads the initial state |
| x_bit | input | 1 | Serial operand bit, LSB first |
| y_bit | output | 1 | Serial result bit of 3·X+1, LSB first, same cycle as `x_bit` |

## Verification
The bound checker covers the state on every cycle. It checks that the initial state is loaded after start (R1). It checks that the previous-bit register follows the input (R2), and it checks the carry update whenever both added bits agree (R3). The bench covers what only complete words can show. It checks each output bit against a behavioural 3·X+1 model in the same cycle (R4, R5). It runs all-zero and all-ones words at the width limits (R6, R7), and it aborts a word that has a live carry and then restarts (R8).

// File: rtl/tpo_pkg.sv
package tpo_pkg;

    // Machine state: last operand bit seen and pending carry
    typedef struct packed {
        logic prev_bit;
        logic carry;
    } tpo_state_t;

    // Result of a three-input single-bit addition
    typedef struct packed {
        logic carry;
        logic sum;
    } tpo_add_t;

    // State at the start of every word: shifted operand begins at zero,
    // the +1 enters as the carry into bit zero
    localparam tpo_state_t TPO_START = '{prev_bit: 1'b0, carry: 1'b1};

    function automatic tpo_add_t tpo_add3(input logic a, input logic b, input logic c);
        tpo_add_t r;
        r.sum   = a ^ b ^ c;
        r.carry = (a & b) | (a & c) | (b & c);
        return r;
    endfunction

endpackage

// File: rtl/tpo_step.sv
module tpo_step
    import tpo_pkg::*;
(
    input  logic       x_bit,
    input  tpo_state_t cur,
    output logic       y_bit,
    output tpo_state_t nxt
);
    tpo_add_t add;

    // X + 2X + carry: the shifted copy of X is the stored previous bit
    always_comb begin
        add          = tpo_add3(x_bit, cur.prev_bit, cur.carry);
        y_bit        = add.sum;
        nxt.prev_bit = x_bit;
        nxt.carry    = add.carry;
    end
endmodule

// File: rtl/tpo_state_reg.sv
module tpo_state_reg
    import tpo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tpo_state_t nxt,
    output tpo_state_t cur
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= TPO_START;
        end else begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/triple_plus_one.sv
module triple_plus_one
    import tpo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x_bit,
    output logic y_bit
);
    tpo_state_t cur_state;
    tpo_state_t nxt_state;

    tpo_step u_step (
        .x_bit (x_bit),
        .cur   (cur_state),
        .y_bit (y_bit),
        .nxt   (nxt_state)
    );

    tpo_state_reg u_state (
        .clk (clk),
        .rst (rst),
        .nxt (nxt_state),
        .cur (cur_state)
    );
endmodule

// File: rtl/tpo_checker.sv
module tpo_checker
    import tpo_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       x_bit,
    input logic       y_bit,
    input tpo_state_t st
);
    // R1: start leaves previous bit 0 and carry 1
    assert_start_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st.prev_bit == 1'b0 && st.carry == 1'b1));

    // R1: first bit of a word comes out inverted
    assert_first_bit_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (y_bit != x_bit));

    // R2: previous-bit register follows the input
    assert_prev_track_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (st.prev_bit == $past(x_bit)));

    // R3: two ones among the added bits force a carry
    assert_carry_set_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(x_bit) && $past(st.prev_bit)) |-> st.carry);

    // R3: two zeros among the added bits clear the carry
    assert_carry_clr_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(x_bit) && !$past(st.prev_bit)) |-> !st.carry);
endmodule

bind triple_plus_one tpo_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .x_bit (x_bit),
    .y_bit (y_bit),
    .st    (cur_state)
);

// File: tb/triple_plus_one_bench.sv
module triple_plus_one_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x_bit = 1'b0;
    logic y_bit;
    int   checks = 0;
    int   fails = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    triple_plus_one u_triple_plus_one (
        .clk   (clk),
        .rst   (rst),
        .x_bit (x_bit),
        .y_bit (y_bit)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Start a word, feed n bits plus two zero pads, compare every cycle
    task automatic run_word(input longint val, input int n, input string req);
        longint expv;
        longint got;
        expv = 3 * val + 1;
        got  = 0;
        @(negedge clk);
        rst   = 1'b1;
        x_bit = 1'b0;
        for (int i = 0; i < n + 2; i++) begin
            @(negedge clk);
            rst   = 1'b0;
            x_bit = (i < n) ? val[i] : 1'b0;
            #5;
            if (i == 0) check(y_bit === ~x_bit, "R1", y_bit, ~x_bit);
            check(y_bit === expv[i], "R4", y_bit, expv[i]);
            got[i] = y_bit;
        end
        check(got == expv, req, got, expv);
    endtask

    // Feed a few bits with no completion, leaving a live carry
    task automatic partial_word(input longint val, input int k);
        @(negedge clk);
        rst   = 1'b1;
        x_bit = 1'b0;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            rst   = 1'b0;
            x_bit = val[i];
        end
    endtask

    initial begin
        #(20 * 20000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        run_word(64'd0, 4, "R6");
        run_word(64'd0, 1, "R6");
        run_word(64'd1, 1, "R5");
        run_word(64'hFF, 8, "R7");
        run_word(64'hFFFF, 16, "R7");
        run_word(64'd1, 1, "R7");
        run_word(64'hA5, 8, "R5");
        partial_word(64'hF, 3);
        run_word(64'd6, 3, "R8");
        partial_word(64'h3, 2);
        run_word(64'd0, 3, "R8");
        for (int w = 0; w < 60; w++) begin
            int     n;
            longint v;
            n = 1 + int'($urandom % 20);
            v = longint'($urandom) & ((longint'(1) << n) - 1);
            run_word(v, n, "R5");
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule